// File: doc/BRIEF.md
# TLB Duplicate Entry Scrubber

After a translation-overlap fault, the main TLB may hold two or more entries for the same page in one set. This sequencer repairs that condition. It visits each set once. It reads the first descriptor word of every configured way through the TLB's entry read port. If any way in the set is valid, it compares the ways pairwise on their page-aligned tags. For every matching pair it erases the lower-numbered way.

A start pulse launches a pass, using the set count and way count present on the inputs in that cycle. The block issues one read or one erase per cycle. Each erase can be accompanied by a report that carries the tag, the set and both way numbers. A quiet input suppresses the reports. A done pulse marks the end of the pass.

Top module: `tlb_dup_scrubber`

## Requirements
- R1: Reads visit sets 0 to S-1 in order. Within a set, reads visit ways 0 to W-1 in order. The linear index is set*W+way. Reads inside one set are issued on consecutive cycles.
- R2: The word on `rd_pd0` is sampled in the cycle after the one in which `rd_req` was high for it.
- R3: The valid bit is bit `VALID_BIT` of the descriptor word. When no way of a set has it set, that set produces no erase and no report.
- R4: The tag is the word with bits [OFF_W-1:0] cleared, so the valid bit is not part of it. A way whose tag is zero never causes an erase.
- R5: Each way i is compared with every later way n > i. On a match, way i is erased at index set*W+i. Way n is never erased. Here, erasing means writing zero to both descriptor words at that index.
- R6: Once a way is erased, it takes no part in later comparisons of that set. For example, three equal ways a<b<c erase a, then b, and never c.
- R7: When `quiet` is low, every erase cycle also raises `dup_valid` with the tag, the set, and the lower and higher way numbers. When `quiet` is high, the erase happens without a report.
- R8: A way count of 0 acts as 1, and a count above 4 acts as 4. A set count of 0 acts as 1, and a count above 2^SET_W acts as 2^SET_W. Both counts are taken at the accepted start.
- R9: `busy` is high from the cycle after an accepted start until the pass ends. A start that arrives while busy is ignored.
- R10: `done` is high for exactly one cycle, after the last set has been handled. `busy` is low in that cycle.
- R11: With a way count of 1, no comparison, erase or report takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a pass while idle |
| num_sets | input | SET_W+1 | Number of sets to scrub |
| num_ways | input | 3 | Number of ways per set |
| quiet | input | 1 | Suppresses duplicate reports |
| rd_req | output | 1 | Entry read request |
| rd_idx | output | SET_W+2 | Linear index of the entry to read |
| rd_pd0 | input | PD_W | First descriptor word, returned one cycle after the request |
| erase_req | output | 1 | Write zeros to both descriptor words of an entry |
| erase_idx | output | SET_W+2 | Linear index of the entry to erase |
| dup_valid | output | 1 | Duplicate report strobe |
| dup_tag | output | PD_W | Tag that was duplicated |
| dup_set | output | SET_W | Set holding the duplicate |
| dup_way_lo | output | 2 | Way that was erased |
| dup_way_hi | output | 2 | Way that was kept |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
An erase and its report fall in the same cycle. A scoreboard checks that every popped report coincides with an erase_req whose index names the same set and lower way. The same scenarios are then rerun with quiet high, which must keep every erase and remove every report. A second start is injected during the read phase of a pass with different counts. Judged against the read and erase queues, it must not change the read order or add any operation.

// File: rtl/tlbs_pkg.sv
package tlbs_pkg;
  localparam int MAX_WAYS = 4;
  localparam int WAY_W    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_EVAL,
    ST_CMP
  } scrub_state_t;
endpackage

// File: rtl/tlbs_tag_bank.sv
module tlbs_tag_bank
  import tlbs_pkg::*;
#(
  parameter int PD_W      = 32,
  parameter int OFF_W     = 13,
  parameter int VALID_BIT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_valid,
  input  logic             cap_en,
  input  logic [WAY_W-1:0] cap_way,
  input  logic [PD_W-1:0]  cap_data,
  input  logic             zap_en,
  input  logic [WAY_W-1:0] zap_way,
  input  logic [WAY_W-1:0] sel_lo,
  input  logic [WAY_W-1:0] sel_hi,
  output logic             any_valid,
  output logic [PD_W-1:0]  tag_lo,
  output logic             pair_match
);
  localparam logic [PD_W-1:0] TAG_MASK = {{(PD_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  logic [MAX_WAYS-1:0][PD_W-1:0] tag_all;

  for (genvar g = 0; g < MAX_WAYS; g++) begin : g_way
    logic [PD_W-1:0] tag_q;
    always_ff @(posedge clk) begin
      if (rst)
        tag_q <= '0;
      else if (zap_en && zap_way == WAY_W'(g))
        tag_q <= '0;
      else if (cap_en && cap_way == WAY_W'(g))
        tag_q <= cap_data & TAG_MASK;
    end
    assign tag_all[g] = tag_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_valid)
      any_valid <= 1'b0;
    else if (cap_en)
      any_valid <= any_valid | cap_data[VALID_BIT];
  end

  assign tag_lo     = tag_all[sel_lo];
  assign pair_match = (tag_lo != '0) && (tag_lo == tag_all[sel_hi]);

  // R6: an erased way drops out of later comparisons
  p_zap_clears_r6: assert property (@(posedge clk) disable iff (rst)
    zap_en |=> tag_all[$past(zap_way)] == '0);
endmodule

// File: rtl/tlbs_ctrl.sv
module tlbs_ctrl
  import tlbs_pkg::*;
#(
  parameter int SET_W = 7,
  parameter int IDX_W = SET_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SET_W:0]   num_sets,
  input  logic [2:0]       num_ways,
  input  logic             any_valid,
  input  logic             pair_match,
  output logic             rd_req,
  output logic [IDX_W-1:0] rd_idx,
  output logic             erase_req,
  output logic [IDX_W-1:0] erase_idx,
  output logic             cap_en,
  output logic [WAY_W-1:0] cap_way,
  output logic             clr_valid,
  output logic [WAY_W-1:0] sel_lo,
  output logic [WAY_W-1:0] sel_hi,
  output logic [SET_W-1:0] cur_set,
  output logic             busy,
  output logic             done
);
  localparam int SET_N = 1 << SET_W;

  scrub_state_t     state;
  logic [SET_W-1:0] set_q, sets_last_q, sets_last_in;
  logic [WAY_W-1:0] way_q, lo_q, hi_q, ways_last_q, ways_last_in;
  logic             set_end, cap_en_q, done_q;
  logic [WAY_W-1:0] cap_way_q;
  logic [IDX_W-1:0] base_idx;

  always_comb begin
    if (num_sets == '0)
      sets_last_in = '0;
    else if (num_sets > (SET_W+1)'(SET_N))
      sets_last_in = '1;
    else
      sets_last_in = SET_W'(num_sets - 1'b1);
    case (num_ways)
      3'd0, 3'd1: ways_last_in = 2'd0;
      3'd2:       ways_last_in = 2'd1;
      3'd3:       ways_last_in = 2'd2;
      default:    ways_last_in = 2'd3;
    endcase
  end

  always_comb begin
    set_end = 1'b0;
    if (state == ST_EVAL)
      set_end = !(any_valid && ways_last_q != '0);
    else if (state == ST_CMP)
      set_end = (hi_q == ways_last_q) && (lo_q == ways_last_q - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      set_q       <= '0;
      way_q       <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      sets_last_q <= '0;
      ways_last_q <= '0;
      cap_en_q    <= 1'b0;
      cap_way_q   <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      cap_en_q  <= (state == ST_READ);
      cap_way_q <= way_q;
      case (state)
        ST_IDLE: if (start) begin
          sets_last_q <= sets_last_in;
          ways_last_q <= ways_last_in;
          set_q       <= '0;
          way_q       <= '0;
          state       <= ST_READ;
        end
        ST_READ: begin
          if (way_q == ways_last_q) state <= ST_WAIT;
          else                      way_q <= way_q + 1'b1;
        end
        ST_WAIT: state <= ST_EVAL;
        ST_EVAL: if (!set_end) begin
          lo_q  <= '0;
          hi_q  <= 2'd1;
          state <= ST_CMP;
        end
        ST_CMP: begin
          if (hi_q == ways_last_q) begin
            lo_q <= lo_q + 1'b1;
            hi_q <= lo_q + 2'd2;
          end else begin
            hi_q <= hi_q + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (set_end) begin
        if (set_q == sets_last_q) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          set_q <= set_q + 1'b1;
          way_q <= '0;
          state <= ST_READ;
        end
      end
    end
  end

  assign base_idx  = IDX_W'(set_q) * (IDX_W'(ways_last_q) + IDX_W'(1));
  assign rd_req    = (state == ST_READ);
  assign rd_idx    = base_idx + IDX_W'(way_q);
  assign erase_req = (state == ST_CMP) && pair_match;
  assign erase_idx = base_idx + IDX_W'(lo_q);
  assign cap_en    = cap_en_q;
  assign cap_way   = cap_way_q;
  assign clr_valid = (state == ST_READ) && (way_q == '0);
  assign sel_lo    = lo_q;
  assign sel_hi    = hi_q;
  assign cur_set   = set_q;
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;

  // R1: reads within a set step by one index per cycle
  p_read_step_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_req && $past(rd_req)) |-> rd_idx == $past(rd_idx) + 1'b1);
  // R3: no erase in a set without a valid way
  p_erase_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> any_valid);
  // R9: a pass only begins after a start request
  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R9: a start while busy leaves the captured counts alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(sets_last_q) && $stable(ways_last_q));
endmodule

// File: rtl/tlb_dup_scrubber.sv
module tlb_dup_scrubber
  import tlbs_pkg::*;
#(
  parameter int SET_W     = 7,
  parameter int PD_W      = 32,
  parameter int OFF_W     = 13,
  parameter int VALID_BIT = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [SET_W:0]     num_sets,
  input  logic [2:0]         num_ways,
  input  logic               quiet,
  output logic               rd_req,
  output logic [SET_W+1:0]   rd_idx,
  input  logic [PD_W-1:0]    rd_pd0,
  output logic               erase_req,
  output logic [SET_W+1:0]   erase_idx,
  output logic               dup_valid,
  output logic [PD_W-1:0]    dup_tag,
  output logic [SET_W-1:0]   dup_set,
  output logic [1:0]         dup_way_lo,
  output logic [1:0]         dup_way_hi,
  output logic               busy,
  output logic               done
);
  localparam int IDX_W = SET_W + 2;

  logic             any_valid, pair_match, cap_en, clr_valid;
  logic [WAY_W-1:0] cap_way, sel_lo, sel_hi;
  logic [PD_W-1:0]  tag_lo;
  logic [SET_W-1:0] cur_set;

  tlbs_ctrl #(.SET_W(SET_W), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .num_sets   (num_sets),
    .num_ways   (num_ways),
    .any_valid  (any_valid),
    .pair_match (pair_match),
    .rd_req     (rd_req),
    .rd_idx     (rd_idx),
    .erase_req  (erase_req),
    .erase_idx  (erase_idx),
    .cap_en     (cap_en),
    .cap_way    (cap_way),
    .clr_valid  (clr_valid),
    .sel_lo     (sel_lo),
    .sel_hi     (sel_hi),
    .cur_set    (cur_set),
    .busy       (busy),
    .done       (done)
  );

  tlbs_tag_bank #(.PD_W(PD_W), .OFF_W(OFF_W), .VALID_BIT(VALID_BIT)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .clr_valid  (clr_valid),
    .cap_en     (cap_en),
    .cap_way    (cap_way),
    .cap_data   (rd_pd0),
    .zap_en     (erase_req),
    .zap_way    (sel_lo),
    .sel_lo     (sel_lo),
    .sel_hi     (sel_hi),
    .any_valid  (any_valid),
    .tag_lo     (tag_lo),
    .pair_match (pair_match)
  );

  assign dup_valid  = erase_req && !quiet;
  assign dup_tag    = tag_lo;
  assign dup_set    = cur_set;
  assign dup_way_lo = sel_lo;
  assign dup_way_hi = sel_hi;

  // R5: the erased way is always the lower one of the pair
  p_lo_below_hi_r5: assert property (@(posedge clk) disable iff (rst)
    dup_valid |-> dup_way_lo < dup_way_hi);
  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: the scrubber is idle when it signals completion
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tb_tlb_dup_scrubber.sv
`timescale 1ns/1ps
module tb_tlb_dup_scrubber;
  localparam int SET_W = 4, PD_W = 32, OFF_W = 13, VALID_BIT = 10;
  localparam int IDX_W = SET_W + 2, NENT = 1 << IDX_W;
  localparam logic [PD_W-1:0] V = 32'h1 << VALID_BIT;
  localparam logic [PD_W-1:0] MASK = {{(PD_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  logic clk = 0, rst = 1, start = 0, quiet = 0;
  logic [SET_W:0] num_sets = 0;
  logic [2:0] num_ways = 0;
  logic rd_req, erase_req, dup_valid, busy, done;
  logic [IDX_W-1:0] rd_idx, erase_idx;
  logic [PD_W-1:0] rd_pd0, dup_tag;
  logic [SET_W-1:0] dup_set;
  logic [1:0] dup_way_lo, dup_way_hi;
  logic ld_en = 0;
  logic [IDX_W-1:0] ld_idx = 0;
  logic [PD_W-1:0] ld_val = 0;
  logic [PD_W-1:0] mem [NENT];

  int n_tests = 0, n_fail = 0;
  int rd_q[$], er_q[$];
  typedef struct packed { logic [PD_W-1:0] tag; logic [SET_W-1:0] set; logic [1:0] lo, hi; } rep_t;
  rep_t rep_q[$];

  always #10 clk = ~clk;

  tlb_dup_scrubber #(.SET_W(SET_W), .PD_W(PD_W), .OFF_W(OFF_W), .VALID_BIT(VALID_BIT)) dut (
    .clk(clk), .rst(rst), .start(start), .num_sets(num_sets), .num_ways(num_ways),
    .quiet(quiet), .rd_req(rd_req), .rd_idx(rd_idx), .rd_pd0(rd_pd0),
    .erase_req(erase_req), .erase_idx(erase_idx), .dup_valid(dup_valid),
    .dup_tag(dup_tag), .dup_set(dup_set), .dup_way_lo(dup_way_lo),
    .dup_way_hi(dup_way_hi), .busy(busy), .done(done));

  // TLB model: one-cycle read latency, erase writes zeros
  always @(posedge clk) begin
    if (rd_req) rd_pd0 <= mem[rd_idx];
    if (erase_req) mem[erase_idx] <= '0;
    if (ld_en) mem[ld_idx] <= ld_val;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as the design acts
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_req) begin
        if (rd_q.size() == 0) chk(0, "R1", "unexpected read", rd_idx, -1);
        else begin
          automatic int e = rd_q.pop_front();
          chk(rd_idx == IDX_W'(e), "R1", "read index", rd_idx, e);
        end
      end
      if (erase_req) begin
        if (er_q.size() == 0) chk(0, "R5", "unexpected erase", erase_idx, -1);
        else begin
          automatic int e = er_q.pop_front();
          chk(erase_idx == IDX_W'(e), "R5", "erase index", erase_idx, e);
        end
      end
      if (dup_valid) begin
        chk(erase_req, "R7", "report without erase", 0, 1);
        if (rep_q.size() == 0) chk(0, "R7", "unexpected report", dup_tag, -1);
        else begin
          automatic rep_t e = rep_q.pop_front();
          automatic rep_t a = '{dup_tag, dup_set, dup_way_lo, dup_way_hi};
          chk(a == e, "R7", "report fields", a, e);
        end
      end
    end
  end

  task automatic load(input int idx, input logic [PD_W-1:0] val);
    @(negedge clk);
    ld_en = 1; ld_idx = IDX_W'(idx); ld_val = val;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic fill_unique();
    for (int i = 0; i < NENT; i++) load(i, (PD_W'(i + 1) << OFF_W) | V);
  endtask

  // Driver-side expectation from the requirements
  task automatic plan(input int sets_in, input int ways_in, input bit q);
    int w_eff, s_eff;
    w_eff = (ways_in == 0) ? 1 : (ways_in > 4 ? 4 : ways_in);
    s_eff = (sets_in == 0) ? 1 : (sets_in > (1 << SET_W) ? (1 << SET_W) : sets_in);
    for (int s = 0; s < s_eff; s++) begin
      logic [PD_W-1:0] t[4];
      bit any = 0;
      for (int w = 0; w < w_eff; w++) begin
        rd_q.push_back(s * w_eff + w);
        any |= mem[s * w_eff + w][VALID_BIT];
        t[w] = mem[s * w_eff + w] & MASK;
      end
      if (any)
        for (int i = 0; i < w_eff - 1; i++)
          for (int n = i + 1; n < w_eff; n++)
            if (t[i] != '0 && t[i] == t[n]) begin
              er_q.push_back(s * w_eff + i);
              if (!q) rep_q.push_back('{t[i], SET_W'(s), 2'(i), 2'(n)});
              t[i] = '0;
            end
    end
  endtask

  task automatic run(input int sets_in, input int ways_in, input bit q, input bit restart);
    int cnt = 0;
    plan(sets_in, ways_in, q);
    @(negedge clk);
    num_sets = (SET_W+1)'(sets_in); num_ways = 3'(ways_in); quiet = q; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R9", "busy after start", busy, 1);
    if (restart) begin
      @(negedge clk);
      start = 1; num_sets = 1; num_ways = 2;
      @(negedge clk);
      start = 0;
    end
    while (!done && cnt < 3000) begin @(negedge clk); cnt++; end
    chk(done, "R10", "done seen", done, 1);
    chk(!busy, "R10", "idle at done", busy, 0);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
    chk(rd_q.size() == 0, "R1", "reads left", rd_q.size(), 0);
    chk(er_q.size() == 0, "R5", "erases left", er_q.size(), 0);
    chk(rep_q.size() == 0, "R7", "reports left", rep_q.size(), 0);
  endtask

  task automatic scenario_a();
    fill_unique();
    load(0, 32'h0004_6000 | V); load(1, 32'h0008_2000 | V);
    load(2, 32'h0004_6000 | V | 32'h5); load(3, 32'h0010_0000);      // R4: offset ignored
    for (int w = 0; w < 4; w++) load(4 + w, 32'h0002_2000);          // R3: all invalid
    load(8, 32'h0030_4000 | V); load(9, 32'h0030_4000 | V);
    load(10, 32'h0040_0000 | V); load(11, 32'h0030_4000 | V);        // R6: triple
    load(12, V); load(13, V | 32'h3);                                // R4: zero tags
    load(14, 32'h0050_0000 | V | 32'h1FF); load(15, 32'h0050_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !rd_req && !erase_req && !dup_valid, "R10", "reset state",
        {busy, done, rd_req, erase_req, dup_valid}, 0);
    scenario_a();
    run(4, 4, 0, 0);                                   // R1 R2 R3 R4 R5 R6 R7
    chk(mem[0] == '0 && mem[2] != '0, "R5", "lower way erased", mem[0], 0);
    chk(mem[8] == '0 && mem[9] == '0 && mem[11] != '0, "R6", "triple keeps last", mem[11], 32'h0030_4000 | V);
    chk(mem[12] != '0, "R4", "zero tag kept", mem[12], V);
    scenario_a();
    run(4, 4, 1, 0);                                   // R7 quiet
    fill_unique();
    load(2, 32'h0077_0000 | V); load(3, 32'h0077_0000 | V);
    run(3, 2, 0, 0);                                   // two ways
    fill_unique();
    load(1, 32'h0066_0000 | V);
    run(4, 1, 0, 0);                                   // R11: no compares
    fill_unique();
    load(4, 32'h0011_0000 | V); load(7, 32'h0011_0000 | V);
    run(3, 7, 0, 0);                                   // R8 way clamp
    fill_unique();
    load(0, 32'h0022_0000 | V); load(1, 32'h0022_0000 | V);
    run(0, 4, 0, 0);                                   // R8 set zero
    run(31, 4, 0, 0);                                  // R8 set clamp
    fill_unique();
    load(20, 32'h0033_0000 | V); load(22, 32'h0033_0000 | V);
    run(6, 4, 0, 1);                                   // R9 start ignored
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule